// File: doc/BRIEF.md
# SPI Master with Two-Step Flag Clearing

This block is an 8-bit SPI master that sits behind a small register interface with three registers: control, status and data. Software writes a byte to the data register to start a transfer. The block then produces SCK and MOSI from the system clock through a selectable divider and captures MISO. When the byte completes, the received byte moves into a receive buffer. Software reads that buffer through the data register.

All four clock-polarity and clock-phase combinations are supported. Bit order can be MSB-first or LSB-first, and a double-speed bit halves the divider. A completion flag can raise an interrupt. A collision flag records a data write made while a transfer is still running. Both flags are cleared either by reading the status register while a flag is set and then accessing the data register, or (for completion) by an acknowledge pulse. When slave select is configured as an input and another master pulls it low, the block aborts the byte in flight, parks SCK at its idle level and raises the completion flag.

Register map (addr_i): 0 = control, 1 = status, 2 = data. Control bits: [7] interrupt enable, [6] block enable, [5] LSB-first, [4] master select, [3] CPOL, [2] CPHA, [1:0] rate. Status bits: [7] transfer complete, [6] write collision, [5:1] zero, [0] double speed.

Top module: `spi_master_regs`

## Requirements
- R1: With control bits [6] and [4] set, a write to address 2 shifts out the byte on MOSI and shifts in 8 MISO bits. It then sets status bit 7 exactly 16*H system clocks after the write edge, where H is the SCK half period. The received byte becomes readable at address 2.
- R2: SCK idles at the level of control bit [3]. With control bit [2] = 0, data is sampled on the leading SCK edge and changed on the trailing edge. With control bit [2] = 1, data is changed on the leading edge and sampled on the trailing edge.
- R3: Control bits [1:0] = 0, 1, 2, 3 select a base divider of 4, 16, 64 or 128 system clocks per SCK period.
- R4: Status bit 0 is readable and writable. When it is set, the divider is halved, so rate 0 gives an SCK period of 2 system clocks.
- R5: Control bit [5] = 1 sends and receives LSB first. Control bit [5] = 0 sends and receives MSB first.
- R6: A data write while a transfer runs sets status bit 6 and is ignored: the byte in flight is sent unchanged.
- R7: Reading status while bit 7 or bit 6 is set, followed by a read or write of address 2, clears both bits. A data access without that prior status read leaves them set.
- R8: irq_o is high exactly when status bit 7, control bit [7] and gie_i are all set. A one-cycle irq_ack_i pulse clears status bit 7.
- R9: Status bits [5:1] always read zero, and writes to them have no effect.
- R10: If slave select is configured as an input (ss_in_mode_i = 1) and ss_ni falls low while the master is enabled, any transfer is aborted, SCK returns to its idle level and status bit 7 is set.
- R11: The receive buffer changes only when a transfer completes. An aborted or in-flight transfer leaves the old value readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (drives the clear sequence) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |
| ss_in_mode_i | input | 1 | Slave select pin configured as input |
| ss_ni | input | 1 | Slave select pin level, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The completion flag and interrupt appear on the clock edge 16*H cycles after the edge that took the data write. The monitor records the cycle in which the write strobe is presented and requires the interrupt to be seen exactly 16*H+1 bench cycles later. Register reads are combinational, so every read is sampled 1 ns after the negative edge that sets the address. The flag-clear effect is checked on the next status read, two edges after the data access. The mode-fault abort is checked at the negative edge directly after the edge that registers the falling slave select.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int REG_W = 8;
  localparam int ADDR_W = 2;
  localparam int HALF_W = 7;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // system clocks per SCK half period
  function automatic logic [HALF_W-1:0] half_cycles(input logic [1:0] rate, input logic dbl);
    logic [HALF_W:0] base;
    case (rate)
      2'd0:    base = 8'd4;
      2'd1:    base = 8'd16;
      2'd2:    base = 8'd64;
      default: base = 8'd128;
    endcase
    base = base >> (dbl ? 2 : 1);
    return base[HALF_W-1:0];
  endfunction
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] half_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  input  logic          abort_i,
  input  logic          tick_i,
  input  logic          cpha_i,
  input  logic          lsb_i,
  input  logic          miso_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          sck_lvl_o,
  output logic          mosi_o,
  output logic [DW-1:0] rx_o
);
  localparam int EDGES = 2 * DW;
  localparam int EW = $clog2(EDGES);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  logic [EW-1:0] edge_q;
  logic [DW-1:0] sh_q, sh_smp, sh_nxt, rx_q;
  logic          busy_q, lvl_q, mosi_q, is_smp;

  assign is_smp = (edge_q[0] == cpha_i);
  assign sh_smp = lsb_i ? {miso_i, sh_q[DW-1:1]} : {sh_q[DW-2:0], miso_i};
  assign sh_nxt = is_smp ? sh_smp : sh_q;
  assign done_o = busy_q && tick_i && (edge_q == LAST) && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      lvl_q  <= 1'b0;
      edge_q <= '0;
      sh_q   <= '0;
      mosi_q <= 1'b0;
      rx_q   <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      lvl_q  <= 1'b0;
      edge_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      lvl_q  <= 1'b0;
      edge_q <= '0;
      sh_q   <= data_i;
      mosi_q <= lsb_i ? data_i[0] : data_i[DW-1];
    end else if (busy_q && tick_i) begin
      lvl_q  <= ~lvl_q;
      edge_q <= edge_q + EW'(1);
      sh_q   <= sh_nxt;
      if (!is_smp) mosi_q <= lsb_i ? sh_q[0] : sh_q[DW-1];
      if (edge_q == LAST) begin
        busy_q <= 1'b0;
        rx_q   <= sh_nxt;
      end
    end
  end

  assign busy_o    = busy_q;
  assign sck_lvl_o = lvl_q;
  assign mosi_o    = mosi_q;
  assign rx_o      = rx_q;
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spi_master_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              irq_ack_i,
  input  logic              gie_i,
  output logic              irq_o,
  input  logic              ss_in_mode_i,
  input  logic              ss_ni,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  ctrl_t             ctrl_q;
  logic              dbl_q, spif_q, wcol_q, arm_q, fault_q;
  logic              busy, done, tick, lvl;
  logic [REG_W-1:0]  rx_buf;
  logic [HALF_W-1:0] half;
  logic              stat_rd, data_acc, data_wr, start, fault_now, fault_rise;

  assign stat_rd    = rd_i && addr_i == ADDR_STAT;
  assign data_wr    = wr_i && addr_i == ADDR_DATA;
  assign data_acc   = (rd_i || wr_i) && addr_i == ADDR_DATA;
  assign start      = data_wr && !busy && ctrl_q.enable && ctrl_q.master;
  assign fault_now  = ctrl_q.enable && ctrl_q.master && ss_in_mode_i && !ss_ni;
  assign fault_rise = fault_now && !fault_q;
  assign half       = half_cycles(ctrl_q.rate, dbl_q);

  spi_clk_div #(.CW(HALF_W)) u_div (
    .clk_i, .rst_ni, .run_i(busy), .half_i(half), .tick_o(tick)
  );

  spi_shift_engine #(.DW(REG_W)) u_eng (
    .clk_i, .rst_ni,
    .start_i(start), .data_i(wdata_i), .abort_i(fault_rise), .tick_i(tick),
    .cpha_i(ctrl_q.cpha), .lsb_i(ctrl_q.lsb_first), .miso_i(miso_i),
    .busy_o(busy), .done_o(done), .sck_lvl_o(lvl), .mosi_o(mosi_o), .rx_o(rx_buf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      dbl_q   <= 1'b0;
      spif_q  <= 1'b0;
      wcol_q  <= 1'b0;
      arm_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= fault_now;
      if (wr_i && addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata_i);
      if (wr_i && addr_i == ADDR_STAT) dbl_q <= wdata_i[0];
      // two-step clear: status read with a flag up arms, data access fires
      if (stat_rd && (spif_q || wcol_q)) arm_q <= 1'b1;
      else if (data_acc)                 arm_q <= 1'b0;
      if (done || fault_rise)                spif_q <= 1'b1;
      else if (irq_ack_i || (data_acc && arm_q)) spif_q <= 1'b0;
      if (data_wr && busy)            wcol_q <= 1'b1;
      else if (data_acc && arm_q)     wcol_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_STAT: rdata_o = {spif_q, wcol_q, 5'b0, dbl_q};
      ADDR_DATA: rdata_o = rx_buf;
      default:   rdata_o = '0;
    endcase
  end

  assign sck_o = ctrl_q.cpol ^ lvl;
  assign irq_o = spif_q && ctrl_q.irq_en && gie_i;
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk
  import spi_master_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              gie_i,
  input logic              irq_o,
  input logic              sck_o,
  input logic              cpol,
  input logic              busy,
  input logic              tick,
  input logic              done,
  input logic              spif,
  input logic              wcol,
  input logic              fault_rise,
  input logic [REG_W-1:0]  rx_buf
);
  AST_DONE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> spif); // R1
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> sck_o == cpol); // R2
  AST_SCK_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !tick && !wr_i && !fault_rise |=> $stable(sck_o)); // R3
  AST_COLLISION_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == ADDR_DATA && busy |=> wcol); // R6
  AST_NO_IRQ_WITHOUT_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_o); // R8
  AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == ADDR_STAT |-> rdata_o[5:1] == 5'd0); // R9
  AST_FAULT_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_rise |=> spif && !busy); // R10
  AST_RXBUF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(rx_buf)); // R11
endmodule

bind spi_master_regs spi_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .rdata_o(rdata_o), .gie_i(gie_i), .irq_o(irq_o), .sck_o(sck_o),
  .cpol(ctrl_q.cpol), .busy(busy), .tick(tick), .done(done), .spif(spif_q),
  .wcol(wcol_q), .fault_rise(fault_rise), .rx_buf(rx_buf)
);

// File: tb/sim_spi_master_regs.sv
`timescale 1ns/1ps
module sim_spi_master_regs;
  logic       clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic       wr = 0, rd = 0, ack = 0, gie = 1, ss_mode = 0, ss_n = 1, miso = 0;
  logic [7:0] wdata = 0, rdata;
  logic       irq, sck, mosi;
  int         checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  spi_master_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .irq_ack_i(ack), .gie_i(gie), .irq_o(irq), .ss_in_mode_i(ss_mode),
    .ss_ni(ss_n), .sck_o(sck), .mosi_o(mosi), .miso_i(miso)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model
  logic       s_act = 0, s_cpol = 0, s_cpha = 0, s_lsb = 0;
  logic [7:0] s_tx = 0, s_rx = 0;
  int         s_idx = 0;
  function automatic logic sbit(input int i);
    return s_lsb ? s_tx[i] : s_tx[7-i];
  endfunction
  task automatic slave_load(input logic [7:0] b, input logic cpol, input logic cpha, input logic lsb);
    s_tx = b; s_rx = 0; s_cpol = cpol; s_cpha = cpha; s_lsb = lsb; s_idx = 0;
    if (!cpha) begin miso = sbit(0); s_idx = 1; end
    s_act = 1;
  endtask
  always @(sck) if (s_act) begin
    automatic logic leading = (sck != s_cpol);
    if (leading ^ s_cpha)
      s_rx = s_lsb ? {mosi, s_rx[7:1]} : {s_rx[6:0], mosi};
    else if (s_idx < 8) begin
      miso = sbit(s_idx); s_idx++;
    end
  end

  // scoreboard
  typedef struct { int start; int len; logic [7:0] tx; string req; } exp_t;
  exp_t q[$];
  int   mon_cnt = 0;
  logic irq_prev = 0;
  always @(negedge clk) begin
    if (irq && !irq_prev) begin
      if (q.size() == 0) check("R8 spurious irq", 1, 0);
      else begin
        automatic exp_t e = q.pop_front();
        check({e.req, " completion cycle"}, cyc - e.start, e.len);
        check({e.req, " byte seen by slave"}, s_rx, e.tx);
      end
      mon_cnt++;
    end
    irq_prev = irq;
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask
  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  function automatic int half(input int rate, input logic dbl);
    int b;
    b = (rate == 0) ? 4 : (rate == 1) ? 16 : (rate == 2) ? 64 : 128;
    return b / (dbl ? 4 : 2);
  endfunction

  task automatic xfer(input string req, input int rate, input logic dbl, input logic cpol,
                      input logic cpha, input logic lsb, input logic [7:0] tx,
                      input logic [7:0] mb, input logic collide);
    logic [7:0] d, old;
    int target;
    bus_wr(2'd0, {1'b1, 1'b1, lsb, 1'b1, cpol, cpha, rate[1:0]});
    bus_wr(2'd1, {7'd0, dbl});
    bus_rd(2'd2, old);
    @(negedge clk);
    check({req, " R2 sck idle"}, sck, cpol);
    slave_load(mb, cpol, cpha, lsb);
    target = mon_cnt + 1;
    @(negedge clk); addr = 2'd2; wdata = tx; wr = 1;
    q.push_back('{cyc, 16 * half(rate, dbl) + 1, tx, req});
    @(negedge clk); wr = 0;
    if (collide) begin
      repeat (8) @(negedge clk);
      bus_wr(2'd2, ~tx);                      // R6 ignored write
      bus_rd(2'd2, d);
      check("R11 rx buffer held mid-transfer", d, old);
    end
    wait (mon_cnt == target);
    bus_rd(2'd1, d);
    check({req, " R1 status after done"}, d, {1'b1, collide, 5'd0, dbl});
    bus_rd(2'd2, d);
    check({req, " R1 received byte"}, d, mb);
    bus_rd(2'd1, d);
    check({req, " R7 flags cleared"}, d, {7'd0, dbl});
    s_act = 0;
  endtask

  initial begin
    automatic int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 150000) begin
        check("watchdog", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset status", rdata, 8'h00);           // addr 0 = ctrl
    check("R2 reset sck", sck, 0);
    check("R8 reset irq", irq, 0);
    bus_rd(2'd1, d); check("R9 reset status reg", d, 8'h00);
    bus_rd(2'd2, d); check("R11 reset rx buffer", d, 8'h00);

    xfer("R1 mode0",  0, 0, 0, 0, 0, 8'hA5, 8'h3C, 0);
    xfer("R2 mode1",  0, 0, 0, 1, 0, 8'h5A, 8'hC3, 0);
    xfer("R2 mode2",  0, 0, 1, 0, 0, 8'h81, 8'h7E, 0);
    xfer("R2 mode3",  0, 0, 1, 1, 0, 8'h0F, 8'hF0, 0);
    xfer("R3 rate1",  1, 0, 0, 0, 0, 8'h96, 8'h69, 0);
    xfer("R3 rate3",  3, 0, 1, 1, 0, 8'h12, 8'h34, 0);
    xfer("R4 dbl r0", 0, 1, 0, 0, 0, 8'hC6, 8'h6C, 0);
    xfer("R4 dbl m3", 0, 1, 1, 1, 0, 8'h3A, 8'hB2, 0);
    xfer("R4 dbl r2", 2, 1, 0, 1, 0, 8'h44, 8'h22, 0);
    xfer("R5 lsb m0", 0, 0, 0, 0, 1, 8'h01, 8'h80, 0);
    xfer("R5 lsb m1", 1, 0, 0, 1, 1, 8'hE2, 8'h4D, 0);
    xfer("R6 collide", 1, 0, 0, 0, 0, 8'h9B, 8'h5E, 1);

    // R7 data access without status read leaves flag; R8 gie gating and ack
    gie = 0;
    bus_wr(2'd0, 8'hD0);
    slave_load(8'h11, 0, 0, 0);
    target_wait: begin
      bus_wr(2'd2, 8'h77);
      repeat (40) @(negedge clk);
    end
    check("R8 irq low with gie off", irq, 0);
    bus_rd(2'd2, d); check("R1 byte R7 case", d, 8'h11);
    bus_rd(2'd1, d); check("R7 flag kept without prior status read", d, 8'h80);
    s_act = 0;
    q.push_back('{cyc, 0, 8'h77, "R8 gie raise"});
    gie = 1;
    @(negedge clk); @(negedge clk);
    check("R8 irq follows gie", irq, 1);
    q.delete();
    @(negedge clk); ack = 1; @(negedge clk); ack = 0;
    @(negedge clk);
    check("R8 irq cleared by ack", irq, 0);
    bus_rd(2'd1, d); check("R8 ack clears flag", d, 8'h00);

    // R9 writes to reserved bits
    bus_wr(2'd1, 8'hFE);
    bus_rd(2'd1, d); check("R9 reserved bits ignore writes", d, 8'h00);
    bus_wr(2'd1, 8'h01);
    bus_rd(2'd1, d); check("R4 dbl readback", d, 8'h01);
    bus_wr(2'd1, 8'h00);

    // R10 mode fault mid transfer, irq disabled
    bus_wr(2'd0, 8'h53);                     // en, master, rate3, mode0
    ss_mode = 1;
    bus_wr(2'd2, 8'hAA);
    repeat (90) @(negedge clk);
    check("R10 sck active before fault", sck, 1);
    ss_n = 0;
    @(negedge clk);
    check("R10 sck idle after fault", sck, 0);
    bus_rd(2'd1, d); check("R10 flag after fault", d, 8'h80);
    repeat (200) @(negedge clk);
    check("R10 sck stays idle", sck, 0);
    bus_rd(2'd2, d); check("R11 rx unchanged after abort", d, 8'h11);
    bus_rd(2'd1, d); check("R7 cleared after fault", d, 8'h00);
    ss_n = 1; ss_mode = 0;

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule